// File: doc/BRIEF.md
# Strobed Port to Single-Cycle Bus Master Bridge

This bridge sits between a small 8-bit controller that talks through a strobed port interface and a single-master, single-cycle Wishbone bus. The controller presents an address on its port identifier and qualifies it with either a write strobe or a read strobe. The bridge turns one such access into one Wishbone cycle. It then hands progress back to the controller through the byte the controller reads on its input port.

A write takes one output access, which starts the bus cycle, followed by input accesses that poll for completion. A read takes at least three input accesses. The first starts the bus cycle. The polling accesses return a status byte. The access that follows the one that reported completion returns the data captured from the bus, and the bridge then goes back to idle. Only one transaction is in flight at a time. A strobe that arrives when the bridge does not expect it is dropped, so a misbehaving program cannot corrupt the sequence.

Top module: `pio_wb_bridge`

## Requirements
- R1: After reset the bus outputs `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are low, and `pio_in` reads 0x00.
- R2: A `pio_wr_stb` while idle latches `pio_id` into `wb_adr_o` and `pio_out` into `wb_dat_o`, and raises `wb_cyc_o`, `wb_stb_o` and `wb_we_o` at the next clock edge.
- R3: A `pio_rd_stb` while idle latches `pio_id` into `wb_adr_o` and raises `wb_cyc_o` and `wb_stb_o` with `wb_we_o` low at the next clock edge. When both strobes arrive in the same idle cycle, the write wins.
- R4: While `wb_cyc_o` is high and no acknowledge is sampled, `wb_cyc_o`, `wb_stb_o`, `wb_we_o`, `wb_adr_o` and `wb_dat_o` hold their values, and `wb_stb_o` always equals `wb_cyc_o`.
- R5: A `wb_ack_i` sampled while `wb_cyc_o` is high drops `wb_cyc_o`, `wb_stb_o` and `wb_we_o` at that edge. For a read, the same edge captures `wb_dat_i`. An acknowledge while `wb_cyc_o` is low has no effect.
- R6: While a bus cycle is pending, `pio_in` reads 0x00. Once the acknowledge has been taken, `pio_in` reads 0x01 (bit 0 is the completion flag and the other bits are zero) until a `pio_rd_stb` consumes it.
- R7: After a write, the `pio_rd_stb` that reads the 0x01 status returns the bridge to idle, so `pio_in` then reads 0x00 and a new access is accepted.
- R8: After a read, the `pio_rd_stb` that reads the 0x01 status makes `pio_in` show the captured bus data. The next `pio_rd_stb` returns the bridge to idle.
- R9: A `pio_wr_stb` in any state other than idle is ignored, and leaves the bus outputs, address, data and `pio_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pio_id | input | 8 | Port identifier from the controller, used as the bus address |
| pio_out | input | 8 | Output byte from the controller, used as write data |
| pio_wr_stb | input | 1 | Output access strobe |
| pio_rd_stb | input | 1 | Input access strobe |
| pio_in | output | 8 | Byte returned to the controller: status or read data |
| wb_adr_o | output | 8 | Bus address |
| wb_dat_o | output | 8 | Bus write data |
| wb_dat_i | input | 8 | Bus read data |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
On every cycle the assertions check the following: the start of a cycle from an idle strobe, with the right address, data and direction; the stability of the bus request while it waits; the drop of the request after an acknowledge; the 0x00 status during a pending cycle; and the completion flag in the cycle after the request falls. Only the bench's scenarios can show the complete polling sequences. These include the captured data reaching `pio_in` only after the status was read, the return to idle, the write winning over a simultaneous read, and a stray acknowledge or a mistimed write strobe leaving no trace.

// File: rtl/pio_wb_pkg.sv
package pio_wb_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int FLAG_IX = 0;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WR_BUSY = 3'd1,
        ST_WR_DONE = 3'd2,
        ST_RD_BUSY = 3'd3,
        ST_RD_DONE = 3'd4,
        ST_RD_DATA = 3'd5
    } bridge_state_t;

    typedef struct packed {
        logic cyc;
        logic stb;
        logic we;
    } bus_ctl_t;

    function automatic logic [DATA_W-1:0] status_byte(input logic done);
        logic [DATA_W-1:0] s;
        s = '0;
        s[FLAG_IX] = done;
        return s;
    endfunction

    function automatic logic is_done_state(input bridge_state_t s);
        return (s == ST_WR_DONE) || (s == ST_RD_DONE);
    endfunction

endpackage

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
    import pio_wb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic          ack_hit,
    output bridge_state_t state,
    output logic          start_wr,
    output logic          start_rd
);

    bridge_state_t nxt;

    assign start_wr = (state == ST_IDLE) && wr_stb;
    assign start_rd = (state == ST_IDLE) && rd_stb && !wr_stb;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (start_wr)      nxt = ST_WR_BUSY;
                else if (start_rd) nxt = ST_RD_BUSY;
            end
            ST_WR_BUSY: if (ack_hit) nxt = ST_WR_DONE;
            ST_RD_BUSY: if (ack_hit) nxt = ST_RD_DONE;
            ST_WR_DONE: if (rd_stb)  nxt = ST_IDLE;
            ST_RD_DONE: if (rd_stb)  nxt = ST_RD_DATA;
            ST_RD_DATA: if (rd_stb)  nxt = ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/wb_cycle_drv.sv
module wb_cycle_drv
    import pio_wb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          ack_in,
    input  logic [DW-1:0] rdata_in,
    output logic          ack_hit,
    output bus_ctl_t      ctl,
    output logic [AW-1:0] adr,
    output logic [DW-1:0] wdat,
    output logic [DW-1:0] rdat
);

    assign ack_hit = ack_in && ctl.cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            adr  <= '0;
            wdat <= '0;
            rdat <= '0;
        end else if (start_wr) begin
            adr  <= addr_in;
            wdat <= wdata_in;
            ctl  <= '{cyc: 1'b1, stb: 1'b1, we: 1'b1};
        end else if (start_rd) begin
            adr  <= addr_in;
            ctl  <= '{cyc: 1'b1, stb: 1'b1, we: 1'b0};
        end else if (ack_hit) begin
            if (!ctl.we) rdat <= rdata_in;
            ctl <= '0;
        end
    end

endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
    import pio_wb_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  bridge_state_t state,
    input  logic [DW-1:0] rdat,
    output logic [DW-1:0] pio_in
);

    always_comb begin
        if (state == ST_RD_DATA) pio_in = rdat;
        else                     pio_in = status_byte(is_done_state(state));
    end

endmodule

// File: rtl/pio_wb_bridge.sv
module pio_wb_bridge
    import pio_wb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] pio_id,
    input  logic [DW-1:0] pio_out,
    input  logic          pio_wr_stb,
    input  logic          pio_rd_stb,
    output logic [DW-1:0] pio_in,
    output logic [AW-1:0] wb_adr_o,
    output logic [DW-1:0] wb_dat_o,
    input  logic [DW-1:0] wb_dat_i,
    output logic          wb_cyc_o,
    output logic          wb_stb_o,
    output logic          wb_we_o,
    input  logic          wb_ack_i
);

    bridge_state_t fsm_state;
    logic          go_wr;
    logic          go_rd;
    logic          ack_hit;
    bus_ctl_t      bus_ctl;
    logic [DW-1:0] cap_data;

    pio_seq_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (pio_wr_stb),
        .rd_stb   (pio_rd_stb),
        .ack_hit  (ack_hit),
        .state    (fsm_state),
        .start_wr (go_wr),
        .start_rd (go_rd)
    );

    wb_cycle_drv #(.AW(AW), .DW(DW)) i_drv (
        .clk      (clk),
        .rst      (rst),
        .start_wr (go_wr),
        .start_rd (go_rd),
        .addr_in  (pio_id),
        .wdata_in (pio_out),
        .ack_in   (wb_ack_i),
        .rdata_in (wb_dat_i),
        .ack_hit  (ack_hit),
        .ctl      (bus_ctl),
        .adr      (wb_adr_o),
        .wdat     (wb_dat_o),
        .rdat     (cap_data)
    );

    pio_rd_mux #(.DW(DW)) i_mux (
        .state  (fsm_state),
        .rdat   (cap_data),
        .pio_in (pio_in)
    );

    assign wb_cyc_o = bus_ctl.cyc;
    assign wb_stb_o = bus_ctl.stb;
    assign wb_we_o  = bus_ctl.we;

endmodule

// File: rtl/pio_wb_bridge_chk.sv
module pio_wb_bridge_chk
    import pio_wb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst,
    input bridge_state_t state,
    input logic [AW-1:0] pio_id,
    input logic [DW-1:0] pio_out,
    input logic          pio_wr_stb,
    input logic          pio_rd_stb,
    input logic [DW-1:0] pio_in,
    input logic [AW-1:0] wb_adr_o,
    input logic [DW-1:0] wb_dat_o,
    input logic          wb_cyc_o,
    input logic          wb_stb_o,
    input logic          wb_we_o,
    input logic          wb_ack_i
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!wb_cyc_o && !wb_stb_o && !wb_we_o));

    // R2
    a_r2_write_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && pio_wr_stb) |=>
            (wb_cyc_o && wb_stb_o && wb_we_o &&
             wb_adr_o == $past(pio_id) && wb_dat_o == $past(pio_out)));

    // R3
    a_r3_read_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && pio_rd_stb && !pio_wr_stb) |=>
            (wb_cyc_o && wb_stb_o && !wb_we_o && wb_adr_o == $past(pio_id)));

    // R4
    a_r4_stb_tracks_cyc: assert property (@(posedge clk) disable iff (rst)
        wb_stb_o == wb_cyc_o);

    a_r4_hold_request: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && !wb_ack_i) |=>
            (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_we_o)));

    // R5
    a_r5_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && wb_ack_i) |=> (!wb_cyc_o && !wb_stb_o && !wb_we_o));

    // R6
    a_r6_pending_zero: assert property (@(posedge clk) disable iff (rst)
        wb_cyc_o |-> (pio_in == '0));

    a_r6_flag_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(wb_cyc_o) |-> (pio_in == status_byte(1'b1)));

endmodule

bind pio_wb_bridge pio_wb_bridge_chk #(.AW(AW), .DW(DW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (fsm_state),
    .pio_id     (pio_id),
    .pio_out    (pio_out),
    .pio_wr_stb (pio_wr_stb),
    .pio_rd_stb (pio_rd_stb),
    .pio_in     (pio_in),
    .wb_adr_o   (wb_adr_o),
    .wb_dat_o   (wb_dat_o),
    .wb_cyc_o   (wb_cyc_o),
    .wb_stb_o   (wb_stb_o),
    .wb_we_o    (wb_we_o),
    .wb_ack_i   (wb_ack_i)
);

// File: tb/test_pio_wb_bridge.sv
`timescale 1ns/1ps
module test_pio_wb_bridge;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pio_id = '0;
    logic [7:0] pio_out = '0;
    logic       pio_wr_stb = 1'b0;
    logic       pio_rd_stb = 1'b0;
    logic [7:0] pio_in;
    logic [7:0] wb_adr_o;
    logic [7:0] wb_dat_o;
    logic [7:0] wb_dat_i = '0;
    logic       wb_cyc_o;
    logic       wb_stb_o;
    logic       wb_we_o;
    logic       wb_ack_i = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    pio_wb_bridge i_pio_wb_bridge (
        .clk(clk), .rst(rst), .pio_id(pio_id), .pio_out(pio_out),
        .pio_wr_stb(pio_wr_stb), .pio_rd_stb(pio_rd_stb), .pio_in(pio_in),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_ack_i(wb_ack_i)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_access(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pio_id = a; pio_out = d; pio_wr_stb = 1'b1;
        @(negedge clk);
        pio_wr_stb = 1'b0;
    endtask

    task automatic rd_access(input logic [7:0] a, output logic [7:0] got);
        @(negedge clk);
        pio_id = a; pio_rd_stb = 1'b1;
        got = pio_in;
        @(negedge clk);
        pio_rd_stb = 1'b0;
    endtask

    task automatic bus_ack(input logic [7:0] d);
        @(negedge clk);
        wb_ack_i = 1'b1; wb_dat_i = d;
        @(negedge clk);
        wb_ack_i = 1'b0; wb_dat_i = 8'h00;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 cyc", int'(wb_cyc_o), 0);
        check("R1 stb", int'(wb_stb_o), 0);
        check("R1 we", int'(wb_we_o), 0);
        check("R1 pio_in", int'(pio_in), 0);
    endtask

    task automatic t_write();
        logic [7:0] g;
        wr_access(8'h12, 8'hA5);
        check("R2 cyc", int'(wb_cyc_o), 1);
        check("R2 stb", int'(wb_stb_o), 1);
        check("R2 we", int'(wb_we_o), 1);
        check("R2 adr", int'(wb_adr_o), 'h12);
        check("R2 dat", int'(wb_dat_o), 'hA5);
        rd_access(8'h12, g);
        check("R6 pending status", int'(g), 0);
        check("R4 cyc held", int'(wb_cyc_o), 1);
        check("R4 adr held", int'(wb_adr_o), 'h12);
        wr_access(8'h99, 8'h11);
        check("R9 adr after stray write", int'(wb_adr_o), 'h12);
        check("R9 dat after stray write", int'(wb_dat_o), 'hA5);
        bus_ack(8'h77);
        check("R5 cyc dropped", int'(wb_cyc_o), 0);
        check("R5 we dropped", int'(wb_we_o), 0);
        check("R6 done status", int'(pio_in), 1);
        rd_access(8'h12, g);
        check("R6 poll sees flag", int'(g), 1);
        check("R7 back to idle", int'(pio_in), 0);
    endtask

    task automatic t_stray_ack();
        bus_ack(8'hEE);
        @(negedge clk);
        check("R5 stray ack cyc", int'(wb_cyc_o), 0);
        check("R5 stray ack pio_in", int'(pio_in), 0);
    endtask

    task automatic t_read();
        logic [7:0] g;
        rd_access(8'h34, g);
        check("R3 setup status", int'(g), 0);
        check("R3 cyc", int'(wb_cyc_o), 1);
        check("R3 we", int'(wb_we_o), 0);
        check("R3 adr", int'(wb_adr_o), 'h34);
        repeat (3) @(negedge clk);
        check("R4 still waiting", int'(wb_cyc_o), 1);
        bus_ack(8'h5C);
        check("R5 read cyc dropped", int'(wb_cyc_o), 0);
        wr_access(8'h01, 8'h02);
        check("R9 write in done state", int'(wb_cyc_o), 0);
        check("R9 status kept", int'(pio_in), 1);
        rd_access(8'h34, g);
        check("R6 read poll flag", int'(g), 1);
        check("R8 data visible", int'(pio_in), 'h5C);
        wr_access(8'h02, 8'h03);
        check("R9 write in data state", int'(pio_in), 'h5C);
        check("R9 no cycle", int'(wb_cyc_o), 0);
        rd_access(8'h34, g);
        check("R8 data returned", int'(g), 'h5C);
        check("R8 back to idle", int'(pio_in), 0);
    endtask

    task automatic t_both_strobes();
        logic [7:0] g;
        @(negedge clk);
        pio_id = 8'h56; pio_out = 8'hC3; pio_wr_stb = 1'b1; pio_rd_stb = 1'b1;
        @(negedge clk);
        pio_wr_stb = 1'b0; pio_rd_stb = 1'b0;
        check("R3 write wins we", int'(wb_we_o), 1);
        check("R3 write wins dat", int'(wb_dat_o), 'hC3);
        bus_ack(8'h00);
        rd_access(8'h56, g);
        check("R7 flag", int'(g), 1);
        check("R7 idle", int'(pio_in), 0);
        wr_access(8'h80, 8'h0F);
        check("R7 new write accepted", int'(wb_adr_o), 'h80);
        bus_ack(8'h00);
        rd_access(8'h80, g);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write();
        t_stray_ack();
        t_read();
        t_both_strobes();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule